// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block picks one interrupt to present to a processor out of a numbered set of request lines. Each line's number is also its vector. A line is eligible when it is both pending and enabled. A per-line level bit places it in the high or the low group. Every high-group request beats every low-group request. Inside a group, the smallest vector number wins. Some vector numbers have no source and are never reported. One source owns a short run of consecutive numbers, and it is always reported by the first number of that run.

The block also tracks which level is in service. After the processor acknowledges a low-level interrupt, only high-level requests are presented, so a low-level handler can be preempted. After a high-level acknowledge, nothing more is presented until the handler returns. A return strobe closes the most recent level and brings back the vector of a preempted low-level handler. With vectored mode off, the level bits and the vector are unused. A single any-request line is raised instead.

Top module: `irq_vec_arb`

## Requirements
- R1: After reset, irq_valid, irq_lvl_hi, irq_any, svc_hi and svc_lo are 0, and irq_vec and act_vec are 0.
- R2: A line takes part only when req and en are both 1 at its index. A pending line whose enable is 0 is never presented.
- R3: Among eligible lines in the same level, the output vector is the smallest index.
- R4: With pri bit 1 (high level), a line wins over every line with pri bit 0, whatever the indices.
- R5: Vector 63 and vector 80 have no source. Requests on them are ignored, and neither value is ever output while irq_valid is 1.
- R6: Lines 72 to 75 form one shared source. A request on any of them is reported as vector 72, using en[72] and pri[72].
- R7: irq_valid, irq_vec and irq_lvl_hi are registered. They show the result of the inputs held before a clock edge right after that edge. When irq_valid is 0, irq_vec and irq_lvl_hi are 0.
- R8: An ack while irq_valid is 1 (vectored mode) copies irq_vec to act_vec and sets svc_hi or svc_lo by irq_lvl_hi. An ack while irq_valid is 0 changes nothing.
- R9: While only svc_lo is set, low-level requests are not presented, and high-level requests are presented.
- R10: While svc_hi is set, irq_valid stays 0.
- R11: ret clears svc_hi if it is set, otherwise svc_lo. After a preempting handler returns, act_vec shows the low-level vector again. act_vec is 0 with nothing in service. A ret in the same cycle as an accepted ack is ignored.
- R12: With vec_en 0, irq_valid stays 0 and irq_any is 1 one clock after any line is eligible under R2, R5 and R6, whatever pri holds. With vec_en 1, irq_any is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vec_en | input | 1 | Vectored mode enable |
| req | input | 81 | Pending flag per vector |
| en | input | 81 | Enable bit per vector |
| pri | input | 81 | Level bit per vector, 1 = high |
| ack | input | 1 | Acknowledge strobe for the presented vector |
| ret | input | 1 | Return-from-interrupt strobe |
| irq_valid | output | 1 | A vector is presented |
| irq_vec | output | 7 | Presented vector |
| irq_lvl_hi | output | 1 | Presented vector is high level |
| irq_any | output | 1 | Non-vectored interrupt request |
| act_vec | output | 7 | Vector of the handler now in service |
| svc_hi | output | 1 | High-level handler in service |
| svc_lo | output | 1 | Low-level handler in service |

## Verification
Every result is due one clock edge after its cause. A request pattern, an ack or a ret applied before an edge shows on irq_valid, irq_vec, irq_lvl_hi, irq_any, act_vec and the service flags right after that same edge. The presentation already takes the new service state into account, so there is no cycle with a stale vector. The bench changes inputs 1 ns after a rising edge and compares 1 ns after the next rising edge, one edge per stimulus. This keeps every sample exactly one register stage from its cause and well away from the edge.

// File: rtl/irq_arb_pkg.sv
// Shared types for the vectored interrupt arbiter.
// Assumes: one service state covers both levels, and a high handler may nest
// on top of a low handler but never the reverse.
package irq_arb_pkg;
    typedef enum logic [1:0] {
        SVC_IDLE = 2'd0,   // nothing in service
        SVC_LO   = 2'd1,   // low-level handler running
        SVC_HI   = 2'd2,   // high-level handler running, no low beneath
        SVC_NEST = 2'd3    // high-level handler preempting a low one
    } svc_state_t;
endpackage

// File: rtl/irq_req_fold.sv
// Qualifies raw requests and splits them into high and low groups.
// Assumes: hole vectors have no source; the alias run ALIAS_LO..ALIAS_HI
// belongs to one source that uses the enable and level bits of ALIAS_LO.
module irq_req_fold #(
    parameter int NUM_VEC = 81,
    parameter logic [NUM_VEC-1:0] HOLE_MAP = NUM_VEC'((128'd1 << 63) | (128'd1 << 80)),
    parameter int ALIAS_LO = 72,
    parameter int ALIAS_HI = 75
) (
    input  logic [NUM_VEC-1:0] req,
    input  logic [NUM_VEC-1:0] en,
    input  logic [NUM_VEC-1:0] pri,
    output logic [NUM_VEC-1:0] q_hi,
    output logic [NUM_VEC-1:0] q_lo
);
    logic [NUM_VEC-1:0] qual;

    // Per-vector qualification chosen at elaboration from the vector's role.
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        if (HOLE_MAP[v]) begin : g_hole
            assign qual[v] = 1'b0;
        end else if (v == ALIAS_LO) begin : g_alias_head
            assign qual[v] = (|req[ALIAS_HI:ALIAS_LO]) & en[v];
        end else if (v > ALIAS_LO && v <= ALIAS_HI) begin : g_alias_tail
            assign qual[v] = 1'b0;
        end else begin : g_plain
            assign qual[v] = req[v] & en[v];
        end
    end

    // Split the qualified set by the user level bit.
    assign q_hi = qual & pri;
    assign q_lo = qual & ~pri;
endmodule

// File: rtl/irq_lowest_pick.sv
// Finds the lowest set index of a request vector (fixed natural order).
// Assumes: index 0 is the highest priority; idx is 0 when nothing is set.
module irq_lowest_pick #(
    parameter int N  = 81,
    parameter int VW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [VW-1:0] idx
);
    // Scan from the top so the last hit, the lowest index, is kept.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = VW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_svc_track.sv
// Tracks which interrupt levels are in service and the vector of each.
// Assumes: ack_ok is only raised for a presented vector, so a low ack never
// arrives while a handler runs; an accepted ack takes precedence over ret.
module irq_svc_track #(
    parameter int VW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack_ok,
    input  logic          ack_hi,
    input  logic [VW-1:0] ack_vec,
    input  logic          ret,
    output logic          svc_hi,
    output logic          svc_lo,
    output logic          svc_hi_n,
    output logic          svc_lo_n,
    output logic [VW-1:0] act_vec
);
    import irq_arb_pkg::*;

    svc_state_t    state_q, state_n;
    logic [VW-1:0] hi_vec_q, lo_vec_q;

    // Next service state from acknowledge and return strobes.
    always_comb begin
        state_n = state_q;
        if (ack_ok) begin
            case (state_q)
                SVC_IDLE: state_n = ack_hi ? SVC_HI : SVC_LO;
                SVC_LO:   if (ack_hi) state_n = SVC_NEST;
                default:  state_n = state_q;
            endcase
        end else if (ret) begin
            case (state_q)
                SVC_LO, SVC_HI: state_n = SVC_IDLE;
                SVC_NEST:       state_n = SVC_LO;
                default:        state_n = state_q;
            endcase
        end
    end

    // Register the service state and latch acknowledged vectors per level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SVC_IDLE;
            hi_vec_q <= '0;
            lo_vec_q <= '0;
        end else begin
            state_q <= state_n;
            if (ack_ok && ack_hi)  hi_vec_q <= ack_vec;
            if (ack_ok && !ack_hi) lo_vec_q <= ack_vec;
        end
    end

    // Level flags, now and after this edge.
    assign svc_hi   = (state_q == SVC_HI)  || (state_q == SVC_NEST);
    assign svc_lo   = (state_q == SVC_LO)  || (state_q == SVC_NEST);
    assign svc_hi_n = (state_n == SVC_HI)  || (state_n == SVC_NEST);
    assign svc_lo_n = (state_n == SVC_LO)  || (state_n == SVC_NEST);

    // The innermost running handler's vector.
    assign act_vec = svc_hi ? hi_vec_q : (svc_lo ? lo_vec_q : '0);
endmodule

// File: rtl/irq_vec_arb.sv
// Top: two-level vectored interrupt arbiter with preemption of low-level
// service by high-level requests, and a plain any-request mode.
// Assumes: single clock, synchronous active-low reset, strobes one cycle wide.
module irq_vec_arb #(
    parameter int NUM_VEC = 81,
    parameter int VW = $clog2(NUM_VEC),
    parameter logic [NUM_VEC-1:0] HOLE_MAP = NUM_VEC'((128'd1 << 63) | (128'd1 << 80)),
    parameter int ALIAS_LO = 72,
    parameter int ALIAS_HI = 75
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vec_en,
    input  logic [NUM_VEC-1:0] req,
    input  logic [NUM_VEC-1:0] en,
    input  logic [NUM_VEC-1:0] pri,
    input  logic               ack,
    input  logic               ret,
    output logic               irq_valid,
    output logic [VW-1:0]      irq_vec,
    output logic               irq_lvl_hi,
    output logic               irq_any,
    output logic [VW-1:0]      act_vec,
    output logic               svc_hi,
    output logic               svc_lo
);
    logic [NUM_VEC-1:0] q_hi, q_lo;
    logic [NUM_VEC-1:0] grp_req [2];
    logic               grp_found [2];
    logic [VW-1:0]      grp_idx [2];
    logic               svc_hi_n, svc_lo_n, ack_ok;
    logic               win_valid, win_hi;
    logic [VW-1:0]      win_vec;

    irq_req_fold #(
        .NUM_VEC(NUM_VEC), .HOLE_MAP(HOLE_MAP),
        .ALIAS_LO(ALIAS_LO), .ALIAS_HI(ALIAS_HI)
    ) u_fold (
        .req(req), .en(en), .pri(pri), .q_hi(q_hi), .q_lo(q_lo)
    );

    assign grp_req[0] = q_lo;
    assign grp_req[1] = q_hi;

    // One natural-order picker per level (0 = low, 1 = high).
    for (genvar g = 0; g < 2; g++) begin : g_lvl
        irq_lowest_pick #(.N(NUM_VEC), .VW(VW)) u_pick (
            .req(grp_req[g]), .found(grp_found[g]), .idx(grp_idx[g])
        );
    end

    assign ack_ok = ack && vec_en && irq_valid;

    irq_svc_track #(.VW(VW)) u_svc (
        .clk(clk), .rst_n(rst_n),
        .ack_ok(ack_ok), .ack_hi(irq_lvl_hi), .ack_vec(irq_vec), .ret(ret),
        .svc_hi(svc_hi), .svc_lo(svc_lo),
        .svc_hi_n(svc_hi_n), .svc_lo_n(svc_lo_n), .act_vec(act_vec)
    );

    // Winner under the service state that holds after this edge.
    always_comb begin
        win_valid = 1'b0;
        win_hi    = 1'b0;
        win_vec   = '0;
        if (vec_en && !svc_hi_n) begin
            if (grp_found[1]) begin
                win_valid = 1'b1;
                win_hi    = 1'b1;
                win_vec   = grp_idx[1];
            end else if (grp_found[0] && !svc_lo_n) begin
                win_valid = 1'b1;
                win_vec   = grp_idx[0];
            end
        end
    end

    // Output register for the presented vector and the plain request line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid  <= 1'b0;
            irq_vec    <= '0;
            irq_lvl_hi <= 1'b0;
            irq_any    <= 1'b0;
        end else begin
            irq_valid  <= win_valid;
            irq_vec    <= win_vec;
            irq_lvl_hi <= win_hi;
            irq_any    <= !vec_en && (|(q_hi | q_lo));
        end
    end
endmodule

// File: rtl/irq_vec_arb_chk.sv
// Property checker for irq_vec_arb, attached by bind.
// Assumes: the same parameters as the bound instance.
module irq_vec_arb_chk #(
    parameter int NUM_VEC = 81,
    parameter int VW = $clog2(NUM_VEC),
    parameter logic [NUM_VEC-1:0] HOLE_MAP = NUM_VEC'((128'd1 << 63) | (128'd1 << 80)),
    parameter int ALIAS_LO = 72,
    parameter int ALIAS_HI = 75
) (
    input logic          clk,
    input logic          rst_n,
    input logic          vec_en,
    input logic          ret,
    input logic          irq_valid,
    input logic [VW-1:0] irq_vec,
    input logic          irq_lvl_hi,
    input logic          svc_hi,
    input logic          svc_lo
);
    logic vec_bad;

    // A presented vector must belong to a real, non-aliased source.
    always_comb begin
        vec_bad = 1'b1;
        if (int'(irq_vec) < NUM_VEC)
            vec_bad = HOLE_MAP[irq_vec] ||
                      (int'(irq_vec) > ALIAS_LO && int'(irq_vec) <= ALIAS_HI);
    end

    p_no_hole_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !vec_bad);

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_vec == '0 && !irq_lvl_hi));

    p_lo_only_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_lo && !svc_hi && irq_valid) |-> irq_lvl_hi);

    p_hi_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        svc_hi |-> !irq_valid);

    p_ret_closes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(svc_hi) |-> $past(ret));

    p_plain_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(vec_en) |-> !irq_valid);
endmodule

bind irq_vec_arb irq_vec_arb_chk #(
    .NUM_VEC(NUM_VEC), .VW(VW), .HOLE_MAP(HOLE_MAP),
    .ALIAS_LO(ALIAS_LO), .ALIAS_HI(ALIAS_HI)
) u_chk (
    .clk(clk), .rst_n(rst_n), .vec_en(vec_en), .ret(ret),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_lvl_hi(irq_lvl_hi),
    .svc_hi(svc_hi), .svc_lo(svc_lo)
);

// File: tb/irq_vec_arb_bench.sv
// Self-checking bench: sweeps single, paired and enable-masked requests
// against an arithmetic model, then walks the service sequence.
module irq_vec_arb_bench;
    localparam int N = 81;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         vec_en = 1'b0;
    logic [N-1:0] req = '0, en = '0, pri = '0;
    logic         ack = 1'b0, ret = 1'b0;
    logic         irq_valid, irq_lvl_hi, irq_any, svc_hi, svc_lo;
    logic [6:0]   irq_vec, act_vec;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    irq_vec_arb u_irq_vec_arb (
        .clk(clk), .rst_n(rst_n), .vec_en(vec_en), .req(req), .en(en),
        .pri(pri), .ack(ack), .ret(ret), .irq_valid(irq_valid),
        .irq_vec(irq_vec), .irq_lvl_hi(irq_lvl_hi), .irq_any(irq_any),
        .act_vec(act_vec), .svc_hi(svc_hi), .svc_lo(svc_lo)
    );

    // Expected {valid, high, vector}: holes 63/80, alias 72..75 -> 72.
    function automatic logic [8:0] model(input logic [N-1:0] r, e, p,
                                         input bit allow_lo);
        logic [N-1:0] q;
        int hi_w, lo_w;
        q = '0;
        hi_w = -1;
        lo_w = -1;
        for (int v = 0; v < N; v++) begin
            if (v == 63 || v == 80) continue;
            if (v >= 72 && v <= 75) begin
                if (r[v] && e[72]) q[72] = 1'b1;
            end else if (r[v] && e[v]) q[v] = 1'b1;
        end
        for (int v = N - 1; v >= 0; v--) begin
            if (q[v] && p[v])  hi_w = v;
            if (q[v] && !p[v]) lo_w = v;
        end
        if (hi_w >= 0) return {1'b1, 1'b1, 7'(hi_w)};
        if (lo_w >= 0 && allow_lo) return {1'b1, 1'b0, 7'(lo_w)};
        return 9'd0;
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // One clock edge, then sample 1 ns later.
    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic pres(input string rq, input logic [8:0] exp);
        chk(rq, {23'd0, irq_valid, irq_lvl_hi, irq_vec}, {23'd0, exp});
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        step; step;
        // R1 reset state
        chk("R1", {irq_valid, irq_lvl_hi, irq_any, svc_hi, svc_lo, irq_vec, act_vec},
            '0);
        rst_n = 1'b1;
        vec_en = 1'b1;
        en = '1;

        // R5 R6 R7: single request at every vector, both levels, one edge later
        for (int lv = 0; lv < 2; lv++) begin
            for (int v = 0; v < N; v++) begin
                req = '0; req[v] = 1'b1;
                pri = lv[0] ? '1 : '0;
                step;
                pres("R5_R6_R7 single", model(req, en, pri, 1'b1));
            end
        end

        // R3 R4: every pair with mixed levels
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                req = '0; req[i] = 1'b1; req[j] = 1'b1;
                pri = '0; pri[i] = (i % 3 == 0); pri[j] = ((i ^ j) & 1) == 1;
                step;
                pres("R3_R4 pair", model(req, en, pri, 1'b1));
            end
        end

        // R2: all pending, one enable at a time
        req = '1;
        pri = '0;
        for (int v = 0; v < N; v++) begin
            en = '0; en[v] = 1'b1;
            step;
            pres("R2 enable", model(req, en, pri, 1'b1));
        end
        en = '0;
        step;
        pres("R2 none enabled", 9'd0);

        // Service sequence
        en = '1; req = '0; pri = '0;
        req[10] = 1'b1;
        step;
        pres("R3 low presented", {2'b10, 7'd10});
        ack = 1'b1; step; ack = 1'b0;
        chk("R8 ack low", {svc_hi, svc_lo, act_vec}, {2'b01, 7'd10});
        pres("R9 low masked", 9'd0);
        req[5] = 1'b1;
        step;
        pres("R9 smaller low masked", 9'd0);
        req[30] = 1'b1; pri[30] = 1'b1;
        step;
        pres("R9 high preempts", {2'b11, 7'd30});
        ack = 1'b1; step; ack = 1'b0;
        chk("R8 ack high", {svc_hi, svc_lo, act_vec}, {2'b11, 7'd30});
        pres("R10 blocked", 9'd0);
        req[2] = 1'b1; pri[2] = 1'b1;
        step;
        pres("R10 high blocked", 9'd0);
        ret = 1'b1; step; ret = 1'b0;
        chk("R11 restore low", {svc_hi, svc_lo, act_vec}, {2'b01, 7'd10});
        pres("R11 high again", {2'b11, 7'd2});
        ret = 1'b1; step; ret = 1'b0;
        chk("R11 idle", {svc_hi, svc_lo, act_vec}, {2'b00, 7'd0});
        pres("R11 idle presents", {2'b11, 7'd2});
        ack = 1'b1; ret = 1'b1; step; ack = 1'b0; ret = 1'b0;
        chk("R11 ret ignored with ack", {svc_hi, svc_lo, act_vec}, {2'b10, 7'd2});
        ret = 1'b1; step; ret = 1'b0;
        req = '0;
        step;
        pres("R8 nothing presented", 9'd0);
        ack = 1'b1; step; ack = 1'b0;
        chk("R8 ack ignored", {svc_hi, svc_lo, act_vec}, {2'b00, 7'd0});

        // R12: plain mode, single requests with alternating level bits
        vec_en = 1'b0;
        for (int v = 0; v < N; v++) begin
            req = '0; req[v] = 1'b1;
            pri = (v % 2 == 1) ? '1 : '0;
            step;
            chk("R12 any", {30'd0, irq_any, irq_valid},
                {30'd0, model(req, en, pri, 1'b1) >> 8, 1'b0});
        end
        en = '0;
        step;
        chk("R12 any disabled", {31'd0, irq_any}, 32'd0);
        en = '1; req = '0; req[4] = 1'b1; vec_en = 1'b1;
        step;
        chk("R12 any off in vectored", {31'd0, irq_any}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule